// File: doc/BRIEF.md
# Self-Selecting Multiplexed Processor Bus Register Port

This block gives a host processor register access over a multiplexed address/data bus. The host first puts an address on the shared bus and pulses the address strobe. It then uses the same bus for data. The port works with two strobe conventions:

- A data strobe plus a read/not-write line.
- Separate active-low read and write strobes.

The port does not use a configuration pin to choose between them. It samples the shared strobe pin when the address strobe rises and decides the convention again for every bus cycle. All bus pins pass through one register stage in the system clock domain before any logic uses them.

The latched 5-bit address decodes a small register map:

- Some addresses read back what was last written, so software can verify its writes.
- Some addresses write a control register but read a status input instead.
- One address feeds a transmit FIFO on writes and drains a receive FIFO on reads. For this address the port produces one-clock push and pop strobes; the FIFOs themselves sit outside the block.
- A channel-control register can be loaded either from the bus or from a serial-side load input. Bit 0 of the master control register chooses which source is used.

The data bus tri-state appears as a data-out word plus an output enable.

Top module: `mbus_port`

## Requirements
- R1: At the clock after the sampled address strobe goes from 0 to 1, the port latches address bits [4:0] of the bus and the bus mode. The mode is the pin `ds_rd_i` at that moment: 0 selects strobe/direction mode, 1 selects separate-strobe mode. Address and mode then hold until the next rise of the address strobe.
- R2: In strobe/direction mode, an access is active while the address strobe is low, `ds_rd_i`=1 and the cycle is open. `rw_wr_i`=1 makes the access a read and `rw_wr_i`=0 makes it a write. A write strobe seen while in this mode, such as `rw_wr_i` pulsing low with `ds_rd_i`=0, does nothing.
- R3: In separate-strobe mode, `ds_rd_i`=0 is a read and `rw_wr_i`=0 is a write. Both are active-low and both need the address strobe low and the cycle open.
- R4: `ad_oe_o` is 1 only while a read access is active, and it is 0 when the bus is idle. While `ad_oe_o` is 1, `ad_o` carries the read value.
- R5: A write takes effect one clock after its strobe's trailing edge, using the data that was on the bus while the strobe was active. Addresses 0 (master control), 1 (serial control) and 3 (station address) read back the last value written to them.
- R6: Address 2 writes frame control and reads `frame_stat_i`. Address 4 writes the interrupt mask and reads `irq_stat_i`.
- R7: A write to address 5 gives exactly one `tx_push_o` clock, with `tx_data_o` holding the written byte. A read of address 5 shows `rx_data_i` during the strobe and then gives exactly one `rx_pop_o` clock. Each push or pop happens once per access, one clock after the strobe's trailing edge.
- R8: Address 8 reads `cc_stat_i`. When master control bit 0 is 1, a bus write to address 8 loads `cc_ctrl_o` and `cc_load_i` is ignored. When bit 0 is 0, bus writes to address 8 are ignored and a clock with `cc_load_i`=1 loads `cc_data_i`.
- R9: Every other address reads as 0, and a write to it changes no register output and produces no push.
- R10: After reset, every register is 0, the mode is separate-strobe, `ad_oe_o` is 0, and no push or pop is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| as_i | input | 1 | address strobe, address latched on its rise |
| ds_rd_i | input | 1 | data strobe (high) or read strobe (low), mode sense pin |
| rw_wr_i | input | 1 | read/not-write line or active-low write strobe |
| ad_i | input | 8 | multiplexed address/data bus, inbound |
| ad_o | output | 8 | read data driven onto the bus |
| ad_oe_o | output | 1 | bus output enable |
| frame_stat_i | input | 8 | frame status, read at address 2 |
| irq_stat_i | input | 8 | interrupt status, read at address 4 |
| rx_data_i | input | 8 | receive FIFO head, read at address 5 |
| cc_stat_i | input | 8 | channel status, read at address 8 |
| cc_load_i | input | 1 | serial-side load of channel control |
| cc_data_i | input | 8 | serial-side channel control value |
| master_o | output | 8 | master control register |
| serial_ctrl_o | output | 8 | serial control register |
| frame_ctrl_o | output | 8 | frame control register |
| station_o | output | 8 | station address register |
| irq_mask_o | output | 8 | interrupt mask register |
| cc_ctrl_o | output | 8 | channel control register |
| tx_push_o | output | 1 | one-clock transmit FIFO push |
| tx_data_o | output | 8 | byte for the transmit FIFO |
| rx_pop_o | output | 1 | one-clock receive FIFO pop |

## Verification
Each result has a fixed latency, counted from the clock edge that first samples the relevant pin through the input register:

| Result | When it is due |
|---|---|
| `ad_oe_o` and `ad_o` | during that clock, after the edge that samples the read strobe active |
| Register writes | on the second clock edge after the strobe change, so one clock after the edge that samples the strobe released |
| Push and pop pulses | on the same edge as register writes, lasting one clock |

The bench drives pins on falling edges and holds each strobe for three clocks. It samples read data two falling edges into the strobe, and checks register outputs only after three idle clocks. Push and pop pulses are counted on every rising edge, so a doubled or missing pulse changes the count that the bench compares after each sweep.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic {
    MODE_STROBE_DIR = 1'b0,
    MODE_SPLIT      = 1'b1
  } bus_mode_e;

  localparam int unsigned A_MASTER  = 0;
  localparam int unsigned A_SERIAL  = 1;
  localparam int unsigned A_FRAME   = 2;
  localparam int unsigned A_STATION = 3;
  localparam int unsigned A_IRQ     = 4;
  localparam int unsigned A_FIFO    = 5;
  localparam int unsigned A_CCHAN   = 8;

  // read qualifier for a given mode and pin levels
  function automatic logic strobe_is_read(bus_mode_e m, logic ds_rd, logic rw_wr);
    if (m == MODE_STROBE_DIR) return ds_rd & rw_wr;
    return ~ds_rd;
  endfunction

  // write qualifier for a given mode and pin levels
  function automatic logic strobe_is_write(bus_mode_e m, logic ds_rd, logic rw_wr);
    if (m == MODE_STROBE_DIR) return ds_rd & ~rw_wr;
    return ~rw_wr;
  endfunction

endpackage

// File: rtl/mbus_pin_reg.sv
module mbus_pin_reg #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/mbus_cycle_ctl.sv
module mbus_cycle_ctl
  import mbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_p,
  input  logic              ds_rd_p,
  input  logic              rw_wr_p,
  input  logic [ADDR_W-1:0] addr_p,
  output logic [ADDR_W-1:0] addr,
  output bus_mode_e         mode,
  output logic              rd_act,
  output logic              wr_act,
  output logic              rd_end,
  output logic              wr_end
);
  logic as_q, open, rd_q, wr_q, as_rise;

  assign as_rise = as_p & ~as_q;
  assign rd_act  = open & ~as_p & strobe_is_read(mode, ds_rd_p, rw_wr_p);
  assign wr_act  = open & ~as_p & strobe_is_write(mode, ds_rd_p, rw_wr_p);
  assign rd_end  = rd_q & ~rd_act;
  assign wr_end  = wr_q & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q <= 1'b0;
      addr <= '0;
      mode <= MODE_SPLIT;
      open <= 1'b0;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      as_q <= as_p;
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (as_rise) begin
        addr <= addr_p;
        mode <= ds_rd_p ? MODE_SPLIT : MODE_STROBE_DIR;
        open <= 1'b1;
      end else if (rd_end || wr_end) begin
        open <= 1'b0;
      end
    end
  end

  // R1: address and mode hold while no new address strobe rise occurs
  a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !as_rise |=> $stable(addr) && $stable(mode));
  // R7: trailing-edge events last a single clock
  a_r7_rd_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !rd_end);
  a_r7_wr_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> !wr_end);
  // R4: no access is active while the address strobe is high
  a_r4_no_access_in_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    as_p |-> !rd_act && !wr_act);
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
  import mbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_act,
  input  logic              wr_end,
  input  logic              rd_end,
  input  logic [DATA_W-1:0] ad_p,
  input  logic [DATA_W-1:0] frame_stat,
  input  logic [DATA_W-1:0] irq_stat,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] cc_stat,
  input  logic              cc_load,
  input  logic [DATA_W-1:0] cc_data,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] master,
  output logic [DATA_W-1:0] serial_ctrl,
  output logic [DATA_W-1:0] frame_ctrl,
  output logic [DATA_W-1:0] station,
  output logic [DATA_W-1:0] irq_mask,
  output logic [DATA_W-1:0] cc_ctrl,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_pop
);
  logic [DATA_W-1:0] wdata;
  logic              cc_from_bus;

  assign cc_from_bus = master[0];

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata       <= '0;
      master      <= '0;
      serial_ctrl <= '0;
      frame_ctrl  <= '0;
      station     <= '0;
      irq_mask    <= '0;
      cc_ctrl     <= '0;
      tx_push     <= 1'b0;
      tx_data     <= '0;
      rx_pop      <= 1'b0;
    end else begin
      if (wr_act) wdata <= ad_p;
      tx_push <= wr_end && hit(addr, A_FIFO);
      rx_pop  <= rd_end && hit(addr, A_FIFO);
      if (wr_end) begin
        if (hit(addr, A_MASTER))  master      <= wdata;
        if (hit(addr, A_SERIAL))  serial_ctrl <= wdata;
        if (hit(addr, A_FRAME))   frame_ctrl  <= wdata;
        if (hit(addr, A_STATION)) station     <= wdata;
        if (hit(addr, A_IRQ))     irq_mask    <= wdata;
        if (hit(addr, A_FIFO))    tx_data     <= wdata;
      end
      if (cc_from_bus) begin
        if (wr_end && hit(addr, A_CCHAN)) cc_ctrl <= wdata;
      end else if (cc_load) begin
        cc_ctrl <= cc_data;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, A_MASTER))  rdata = master;
    if (hit(addr, A_SERIAL))  rdata = serial_ctrl;
    if (hit(addr, A_FRAME))   rdata = frame_stat;
    if (hit(addr, A_STATION)) rdata = station;
    if (hit(addr, A_IRQ))     rdata = irq_stat;
    if (hit(addr, A_FIFO))    rdata = rx_data;
    if (hit(addr, A_CCHAN))   rdata = cc_stat;
  end

  // R7: push and pop are single-clock pulses and never coincide
  a_r7_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);
  a_r7_pop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);
  a_r7_push_pop_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && rx_pop));
  // R5: master control changes only after a write ends
  a_r5_master_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_end |=> $stable(master));
  // R8: with bus source selected, channel control moves only on a write end
  a_r8_cc_bus_source: assert property (@(posedge clk) disable iff (!rst_n)
    cc_from_bus && !wr_end |=> $stable(cc_ctrl));
endmodule

// File: rtl/mbus_port.sv
module mbus_port
  import mbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic              ds_rd_i,
  input  logic              rw_wr_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] frame_stat_i,
  input  logic [DATA_W-1:0] irq_stat_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [DATA_W-1:0] cc_stat_i,
  input  logic              cc_load_i,
  input  logic [DATA_W-1:0] cc_data_i,
  output logic [DATA_W-1:0] master_o,
  output logic [DATA_W-1:0] serial_ctrl_o,
  output logic [DATA_W-1:0] frame_ctrl_o,
  output logic [DATA_W-1:0] station_o,
  output logic [DATA_W-1:0] irq_mask_o,
  output logic [DATA_W-1:0] cc_ctrl_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_pop_o
);
  localparam int unsigned CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_p;
  logic [DATA_W-1:0] ad_p, rdata;
  logic [ADDR_W-1:0] addr;
  bus_mode_e         mode;
  logic              rd_act, wr_act, rd_end, wr_end;

  mbus_pin_reg #(.W(CTRL_W), .RST_VAL(3'b011)) u_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .d({as_i, ds_rd_i, rw_wr_i}), .q(ctrl_p));

  mbus_pin_reg #(.W(DATA_W), .RST_VAL('0)) u_ad_reg (
    .clk(clk), .rst_n(rst_n), .d(ad_i), .q(ad_p));

  mbus_cycle_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .as_p(ctrl_p[2]), .ds_rd_p(ctrl_p[1]), .rw_wr_p(ctrl_p[0]),
    .addr_p(ad_p[ADDR_W-1:0]),
    .addr(addr), .mode(mode),
    .rd_act(rd_act), .wr_act(wr_act), .rd_end(rd_end), .wr_end(wr_end));

  mbus_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .wr_act(wr_act), .wr_end(wr_end), .rd_end(rd_end), .ad_p(ad_p),
    .frame_stat(frame_stat_i), .irq_stat(irq_stat_i),
    .rx_data(rx_data_i), .cc_stat(cc_stat_i),
    .cc_load(cc_load_i), .cc_data(cc_data_i),
    .rdata(rdata), .master(master_o), .serial_ctrl(serial_ctrl_o),
    .frame_ctrl(frame_ctrl_o), .station(station_o), .irq_mask(irq_mask_o),
    .cc_ctrl(cc_ctrl_o), .tx_push(tx_push_o), .tx_data(tx_data_o),
    .rx_pop(rx_pop_o));

  assign ad_oe_o = rd_act;
  assign ad_o    = rd_act ? rdata : '0;

  // R4: the bus is never driven during a write access
  a_r4_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act && mode == MODE_STROBE_DIR |-> !ad_oe_o);
endmodule

// File: tb/sim_mbus_port.sv
module sim_mbus_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FRAME_ST = 8'h5A;
  localparam logic [7:0] IRQ_ST   = 8'hC3;
  localparam logic [7:0] RX_HEAD  = 8'h96;
  localparam logic [7:0] CC_ST    = 8'h71;

  logic clk = 1'b0, rst_n = 1'b0;
  logic as_i = 1'b0, ds_rd_i = 1'b1, rw_wr_i = 1'b1;
  logic [7:0] ad_i = '0, ad_o, cc_data_i = '0;
  logic ad_oe_o, cc_load_i = 1'b0;
  logic [7:0] master_o, serial_ctrl_o, frame_ctrl_o, station_o, irq_mask_o, cc_ctrl_o, tx_data_o;
  logic tx_push_o, rx_pop_o;

  int n_tests = 0, n_fail = 0, n_push = 0, n_pop = 0;
  logic [7:0] last_push = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_port u0 (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_rd_i(ds_rd_i), .rw_wr_i(rw_wr_i),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .frame_stat_i(FRAME_ST), .irq_stat_i(IRQ_ST), .rx_data_i(RX_HEAD), .cc_stat_i(CC_ST),
    .cc_load_i(cc_load_i), .cc_data_i(cc_data_i),
    .master_o(master_o), .serial_ctrl_o(serial_ctrl_o), .frame_ctrl_o(frame_ctrl_o),
    .station_o(station_o), .irq_mask_o(irq_mask_o), .cc_ctrl_o(cc_ctrl_o),
    .tx_push_o(tx_push_o), .tx_data_o(tx_data_o), .rx_pop_o(rx_pop_o));

  always @(posedge clk) begin
    if (tx_push_o) begin n_push++; last_push = tx_data_o; end
    if (rx_pop_o) n_pop++;
  end

  function automatic logic [7:0] pat(int a, int m);
    return 8'((a * 37 + m * 91 + 5) % 256);
  endfunction

  function automatic logic [7:0] exp_read(int a, int m);
    case (a)
      0, 1, 3: return pat(a, m);
      2: return FRAME_ST;
      4: return IRQ_ST;
      5: return RX_HEAD;
      8: return CC_ST;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // split: 1 = separate strobes, 0 = strobe/direction
  task automatic bus_cycle(input bit split, input bit rd, input logic [4:0] a,
                           input logic [7:0] wd, output logic [7:0] got, output logic oe);
    @(negedge clk); ds_rd_i = split; rw_wr_i = 1'b1; ad_i = {3'b000, a}; as_i = 1'b1;
    @(negedge clk); as_i = 1'b0;
    @(negedge clk); ad_i = rd ? 8'hEE : wd; if (!split) rw_wr_i = rd;
    @(negedge clk);
    if (split) begin if (rd) ds_rd_i = 1'b0; else rw_wr_i = 1'b0; end
    else ds_rd_i = 1'b1;
    repeat (2) @(negedge clk);
    got = ad_o; oe = ad_oe_o;
    @(negedge clk);
    if (split) begin ds_rd_i = 1'b1; rw_wr_i = 1'b1; end else ds_rd_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic oe;
    int pushes0, pops0;
    logic [7:0] cc_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ad_oe", ad_oe_o, 0);
    chk("R10 master", master_o, 0);
    chk("R10 cc_ctrl", cc_ctrl_o, 0);
    chk("R10 push/pop", {tx_push_o, rx_pop_o}, 0);

    cc_exp = 8'h00;
    for (int m = 0; m < 2; m++) begin
      pushes0 = n_push; pops0 = n_pop;
      for (int a = 0; a < 32; a++) begin
        bus_cycle(m[0], 1'b0, 5'(a), pat(a, m), got, oe);
        // R4: no drive during a write
        chk("R4 oe low on write", oe, 0);
      end
      // R8: mode 0 writes master bit0=1 first, so address 8 lands; mode 1 clears it
      if (pat(0, m) & 8'h01) cc_exp = pat(8, m);
      chk(m ? "R3 master" : "R2 master", master_o, pat(0, m));
      chk("R5 serial_ctrl", serial_ctrl_o, pat(1, m));
      chk("R6 frame_ctrl", frame_ctrl_o, pat(2, m));
      chk("R5 station", station_o, pat(3, m));
      chk("R6 irq_mask", irq_mask_o, pat(4, m));
      chk("R8 cc_ctrl bus write gating", cc_ctrl_o, cc_exp);
      chk("R7 push count", n_push - pushes0, 1);
      chk("R7 push data", last_push, pat(5, m));
      chk("R9 unmapped writes do not push", tx_data_o, pat(5, m));
      for (int a = 0; a < 32; a++) begin
        bus_cycle(m[0], 1'b1, 5'(a), 8'h00, got, oe);
        chk(m ? "R3 read oe" : "R2 read oe", oe, 1);
        chk((a == 0 || a == 1 || a == 3) ? "R5 readback" :
            (a == 2 || a == 4) ? "R6 status read" :
            (a == 5) ? "R7 fifo read" : (a == 8) ? "R8 cc status" : "R9 unmapped read",
            got, exp_read(a, m));
      end
      chk("R7 pop count", n_pop - pops0, 1);
      chk("R4 idle no drive", ad_oe_o, 0);
    end

    // R8: master bit0 now 0, serial load is taken
    @(negedge clk); cc_data_i = 8'hA7; cc_load_i = 1'b1;
    @(negedge clk); cc_load_i = 1'b0;
    chk("R8 serial load taken", cc_ctrl_o, 8'hA7);
    bus_cycle(1'b1, 1'b0, 5'd8, 8'h44, got, oe);
    chk("R8 bus write ignored when bit0=0", cc_ctrl_o, 8'hA7);
    bus_cycle(1'b1, 1'b0, 5'd0, 8'h01, got, oe);
    @(negedge clk); cc_data_i = 8'h3C; cc_load_i = 1'b1;
    @(negedge clk); cc_load_i = 1'b0;
    chk("R8 serial load ignored when bit0=1", cc_ctrl_o, 8'hA7);
    bus_cycle(1'b0, 1'b0, 5'd8, 8'h19, got, oe);
    chk("R8 bus write taken when bit0=1", cc_ctrl_o, 8'h19);

    // R1: cycle latched in strobe/direction mode ignores a separate-strobe write pulse
    @(negedge clk); ds_rd_i = 1'b0; rw_wr_i = 1'b1; ad_i = 8'h00; as_i = 1'b1;
    @(negedge clk); as_i = 1'b0;
    @(negedge clk); ad_i = 8'hFF;
    @(negedge clk); rw_wr_i = 1'b0;
    repeat (3) @(negedge clk); rw_wr_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mode latched, write pulse ignored", master_o, 8'h01);
    chk("R1 no drive", ad_oe_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule